// File: doc/BRIEF.md
# Far-Jump Opcode Substitution Address Extender

This block lets an 8-bit microcontroller with a 16-bit program counter run code from a 512 KB flash. It sits on the program-fetch path between the flash data bus and the CPU. It supplies the three flash address bits above the CPU's own sixteen. The CPU drives bits 15..0 and the block drives bits 18..16.

Code reaches a page other than the current one through a short absolute-jump opcode. That opcode is recognised by its low five bits being 00001, and its top three bits name the target page. When such an opcode arrives on an opcode fetch, the block does three things:
- It keeps the page bits in a holding register.
- It hands the CPU the long-jump opcode 0x02 instead, so the CPU reads the next two bytes unchanged as a full 16-bit target.
- Once both of those operand bytes have been fetched, it moves the held page into the register that drives the upper address bits.

Every other byte passes straight through from flash to CPU with no delay.

Top module: `far_jump_extender`

## Requirements
- R1: While reset is high at a clock edge, the page output and the held page clear to 0, and any pending operand count is abandoned.
- R2: In a cycle with the fetch strobe high, the opcode-fetch flag high and no substitution pending, a flash byte whose bits 4..0 equal 00001 reaches the CPU as 0x02 in that same cycle.
- R3: In the same conditions, a byte whose bits 4..0 differ from 00001 reaches the CPU unchanged in that cycle.
- R4: A byte fetched with the opcode-fetch flag low reaches the CPU unchanged, even when bits 4..0 equal 00001.
- R5: The first two strobed fetches after a substitution pass through unchanged, even when flagged as opcode fetches and matching the pattern.
- R6: The page output keeps its value through the substitution and the first operand fetch. It takes the substituted opcode's bits 7..5 (bit 7 to address bit 18, bit 5 to address bit 16) at the clock edge that ends the second operand fetch.
- R7: A cycle with the fetch strobe low passes the flash byte through, never substitutes, does not advance the operand count and leaves the page output unchanged.
- R8: Once the second operand fetch has completed, the very next matching opcode fetch is substituted again.
- R9: The page output holds its value across any number of ordinary fetches until the next commit.
- R10: After a reset that interrupts a pending substitution, the next matching opcode fetch is substituted at once and the page output stays 0 until that new substitution commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_stb | input | 1 | High in a cycle in which a program byte is fetched |
| op_fetch | input | 1 | High when the current fetch is the first byte of an instruction |
| flash_data | input | 8 | Byte read from flash |
| cpu_data | output | 8 | Byte handed to the CPU (combinational) |
| page_hi | output | 3 | Flash address bits 18..16 |

## Verification
The byte handed to the CPU is combinational, so its expected value is due in the same cycle as the stimulus. The bench drives inputs just after a falling edge and compares the CPU byte one time step later, before the next rising edge.

The page output is registered, so its value is due one rising edge after the second operand fetch. The bench reads it one step after each rising edge, and every vector carries the page expected after that edge. Vectors with the strobe low are placed inside pending windows, so that an idle cycle that advanced the count would move the commit one vector too early and be caught.

// File: rtl/fjx_pkg.sv
package fjx_pkg;

    localparam int BYTE_W = 8;
    localparam int PAGE_W = 3;
    localparam int TAG_W  = 5;

    localparam logic [TAG_W-1:0]  SHORT_JUMP_TAG = 5'b00001;
    localparam logic [BYTE_W-1:0] LONG_JUMP_OP   = 8'h02;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic  hit;
        page_t page;
    } detect_t;

    typedef enum logic {
        PH_IDLE    = 1'b0,
        PH_OPERAND = 1'b1
    } phase_e;

    function automatic logic is_short_jump(byte_t b);
        return b[TAG_W-1:0] == SHORT_JUMP_TAG;
    endfunction

    function automatic page_t page_field(byte_t b);
        return b[BYTE_W-1 -: PAGE_W];
    endfunction

endpackage

// File: rtl/fjx_detect.sv
module fjx_detect
    import fjx_pkg::*;
(
    input  logic    fetch_stb,
    input  logic    op_fetch,
    input  logic    armed,
    input  byte_t   flash_data,
    output detect_t det,
    output byte_t   cpu_data
);
    always_comb begin
        det.hit  = fetch_stb & op_fetch & armed & is_short_jump(flash_data);
        det.page = page_field(flash_data);
        cpu_data = det.hit ? LONG_JUMP_OP : flash_data;
    end
endmodule

// File: rtl/fjx_tracker.sv
module fjx_tracker #(
    parameter int OPERAND_BYTES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fetch_stb,
    input  logic start,
    output logic armed,
    output logic commit
);
    import fjx_pkg::*;

    localparam int CNT_W = $clog2(OPERAND_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OPERAND_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    phase_e           phase;
    logic [CNT_W-1:0] remaining;

    assign armed  = (phase == PH_IDLE);
    assign commit = (phase == PH_OPERAND) && fetch_stb && (remaining == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            remaining <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_OPERAND;
                        remaining <= CNT_LOAD;
                    end
                end
                PH_OPERAND: begin
                    if (fetch_stb) begin
                        remaining <= remaining - CNT_LAST;
                        if (remaining == CNT_LAST) begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fjx_page_reg.sv
module fjx_page_reg
    import fjx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  page_t load_page,
    input  logic  commit,
    output page_t hold_page,
    output page_t page_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_page <= '0;
            page_hi   <= '0;
        end else begin
            if (load) begin
                hold_page <= load_page;
            end
            if (commit) begin
                page_hi <= hold_page;
            end
        end
    end
endmodule

// File: rtl/far_jump_extender.sv
module far_jump_extender
    import fjx_pkg::*;
#(
    parameter int OPERAND_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_stb,
    input  logic              op_fetch,
    input  logic [BYTE_W-1:0] flash_data,
    output logic [BYTE_W-1:0] cpu_data,
    output logic [PAGE_W-1:0] page_hi
);
    detect_t det;
    logic    armed;
    logic    commit;
    page_t   hold_page;

    fjx_detect u_detect (
        .fetch_stb  (fetch_stb),
        .op_fetch   (op_fetch),
        .armed      (armed),
        .flash_data (flash_data),
        .det        (det),
        .cpu_data   (cpu_data)
    );

    fjx_tracker #(.OPERAND_BYTES(OPERAND_BYTES)) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .fetch_stb (fetch_stb),
        .start     (det.hit),
        .armed     (armed),
        .commit    (commit)
    );

    fjx_page_reg u_page (
        .clk       (clk),
        .rst       (rst),
        .load      (det.hit),
        .load_page (det.page),
        .commit    (commit),
        .hold_page (hold_page),
        .page_hi   (page_hi)
    );
endmodule

// File: rtl/fjx_checker.sv
module fjx_checker
    import fjx_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  fetch_stb,
    input logic  op_fetch,
    input byte_t flash_data,
    input byte_t cpu_data,
    input page_t page_hi,
    input logic  commit,
    input page_t hold_page
);
    AST_RESET_CLEARS_PAGE: assert property (@(posedge clk)
        rst |=> (page_hi == '0)); // R1

    AST_ONLY_JUMP_REWRITTEN: assert property (@(posedge clk) disable iff (rst)
        (cpu_data != flash_data) |-> (cpu_data == LONG_JUMP_OP && fetch_stb && op_fetch
                                      && flash_data[TAG_W-1:0] == SHORT_JUMP_TAG)); // R2

    AST_DATA_FETCH_PASSES: assert property (@(posedge clk) disable iff (rst)
        (fetch_stb && !op_fetch) |-> (cpu_data == flash_data)); // R4

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (cpu_data != flash_data) |=> (cpu_data == flash_data)); // R5

    AST_PAGE_HOLDS_AT_SUBST: assert property (@(posedge clk) disable iff (rst)
        (cpu_data != flash_data) |=> $stable(page_hi)); // R6

    AST_COMMIT_TAKES_HOLD: assert property (@(posedge clk) disable iff (rst)
        commit |=> (page_hi == $past(hold_page))); // R6

    AST_IDLE_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
        !fetch_stb |=> $stable(page_hi)); // R7
endmodule

bind far_jump_extender fjx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_stb  (fetch_stb),
    .op_fetch   (op_fetch),
    .flash_data (flash_data),
    .cpu_data   (cpu_data),
    .page_hi    (page_hi),
    .commit     (commit),
    .hold_page  (hold_page)
);

// File: tb/tb_far_jump_extender.sv
`timescale 1ns/1ps
module tb_far_jump_extender;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fetch_stb = 1'b0;
    logic       op_fetch = 1'b0;
    logic [7:0] flash_data = 8'h00;
    logic [7:0] cpu_data;
    logic [2:0] page_hi;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    far_jump_extender dut (
        .clk        (clk),
        .rst        (rst),
        .fetch_stb  (fetch_stb),
        .op_fetch   (op_fetch),
        .flash_data (flash_data),
        .cpu_data   (cpu_data),
        .page_hi    (page_hi)
    );

    typedef struct packed {
        logic       stb;
        logic       op;
        logic [7:0] din;
        logic [7:0] exp_out;
        logic [2:0] exp_page;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 8'h74, 8'h74, 3'd0, 4'd3},  // R3 ordinary opcode
        '{1'b1, 1'b0, 8'h21, 8'h21, 3'd0, 4'd4},  // R4 pattern on data fetch
        '{1'b1, 1'b1, 8'hA1, 8'h02, 3'd0, 4'd2},  // R2 page 5 held
        '{1'b1, 1'b0, 8'h12, 8'h12, 3'd0, 4'd6},  // R6 first operand, page unchanged
        '{1'b0, 1'b1, 8'h41, 8'h41, 3'd0, 4'd7},  // R7 idle cycle inside window
        '{1'b1, 1'b1, 8'h61, 8'h61, 3'd5, 4'd5},  // R5 flagged pattern as operand; R6 commit
        '{1'b1, 1'b1, 8'h61, 8'h02, 3'd5, 4'd8},  // R8 immediate re-substitution, page 3
        '{1'b1, 1'b0, 8'h00, 8'h00, 3'd5, 4'd6},
        '{1'b1, 1'b0, 8'hFF, 8'hFF, 3'd3, 4'd6},  // R6 commit page 3
        '{1'b1, 1'b1, 8'hE4, 8'hE4, 3'd3, 4'd9},  // R9 page persists
        '{1'b0, 1'b1, 8'h01, 8'h01, 3'd3, 4'd7},  // R7 no strobe, no substitution
        '{1'b1, 1'b1, 8'h01, 8'h02, 3'd3, 4'd2},  // R2 page 0 held
        '{1'b1, 1'b0, 8'h34, 8'h34, 3'd3, 4'd9},
        '{1'b1, 1'b0, 8'h56, 8'h56, 3'd0, 4'd6},
        '{1'b1, 1'b1, 8'hE1, 8'h02, 3'd0, 4'd2},  // R2 page 7 held
        '{1'b1, 1'b0, 8'h11, 8'h11, 3'd0, 4'd6},
        '{1'b1, 1'b0, 8'h22, 8'h22, 3'd7, 4'd6},
        '{1'b1, 1'b1, 8'h41, 8'h02, 3'd7, 4'd8},  // R8 page 2 held
        '{1'b1, 1'b0, 8'h01, 8'h01, 3'd7, 4'd5},  // R5 operand matching pattern
        '{1'b1, 1'b1, 8'h81, 8'h81, 3'd2, 4'd5}   // R5 second operand flagged; commit 2
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic o, input logic [7:0] d);
        @(negedge clk);
        fetch_stb  = s;
        op_fetch   = o;
        flash_data = d;
        #1;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        after_edge();
        after_edge();
        // R1 reset state
        check({5'd0, page_hi}, 8'h00, 1, "page after reset");
        drive(1'b1, 1'b1, 8'h5A);
        check(cpu_data, 8'h5A, 1, "passthrough during reset");
        rst = 1'b0;
        drive(1'b0, 1'b0, 8'h00);
        after_edge();

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].stb, VECS[i].op, VECS[i].din);
            check(cpu_data, VECS[i].exp_out, int'(VECS[i].req), "cpu byte");
            after_edge();
            check({5'd0, page_hi}, {5'd0, VECS[i].exp_page}, int'(VECS[i].req), "page");
        end

        // R10 reset interrupting a pending substitution
        drive(1'b1, 1'b1, 8'hC1);
        check(cpu_data, 8'h02, 10, "subst before reset");
        after_edge();
        drive(1'b1, 1'b0, 8'h10);
        after_edge();
        rst = 1'b1;
        drive(1'b0, 1'b0, 8'h00);
        after_edge();
        check({5'd0, page_hi}, 8'h00, 1, "page cleared by reset");
        rst = 1'b0;
        drive(1'b1, 1'b1, 8'h21);
        check(cpu_data, 8'h02, 10, "subst right after reset");
        after_edge();
        check({5'd0, page_hi}, 8'h00, 10, "page held at subst");
        drive(1'b1, 1'b0, 8'h33);
        after_edge();
        check({5'd0, page_hi}, 8'h00, 10, "page after first operand");
        drive(1'b1, 1'b0, 8'h44);
        after_edge();
        check({5'd0, page_hi}, 8'h01, 10, "page after second operand");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule